// File: doc/BRIEF.md
# Serial I2S Sign-Extending Attenuator

This block sits in series with an I2S link and lowers the level of both channels by a fixed power of two. It never collects whole words. It works on the serial bit stream as the bits go by. Each channel slot is 32 bit clocks long. The source places a two's-complement sample MSB-first at the start of the slot. The block shifts the slot content later by 2 or 3 bit periods, which gives roughly 12 dB or 18 dB of attenuation. The bit positions freed at the top of the slot are filled with copies of the sign bit. Bits pushed past the end of the slot are dropped.

Slot start is found from a registered copy of word select. The first data bit of a slot follows one bit clock after the word-select change. Serial data and word select are captured on the rising edge of the bit clock and launched on the falling edge. The downstream receiver therefore sees the same frame alignment and a half-period of setup and hold. The attenuation choice is taken only at the start of a slot. Until the first word-select change after reset, the output data stays low.

Top module: `i2s_shift_attn`

## Requirements
- R1: While rst_ni is low, sd_o and ws_o are 0 whatever sd_i carries.
- R2: After reset, sd_o stays 0 until a word-select change has been seen. That includes the bit period in which the change itself occurs.
- R3: ws_o during each output bit period equals the ws_i value captured for the corresponding input bit, so frame alignment is unchanged.
- R4: Slot position 0 is the bit after the bit clock whose rising edge first saw the new word-select level. That bit is the slot MSB and is output unchanged.
- R5: With shift_sel_i = 0, output slot positions 0..2 all carry the MSB. Output position p >= 2 carries input position p-2 of the same slot.
- R6: With shift_sel_i = 1, output slot positions 0..3 all carry the MSB. Output position p >= 3 carries input position p-3 of the same slot.
- R7: The fill bits are copies of the sign bit: ones for a negative sample and zeros for a positive one. For example, 1011... becomes 111011... at shift 2.
- R8: Input bits moved past slot position 31 are discarded. Output positions 1..N of a slot never carry bits from the previous slot.
- R9: shift_sel_i is sampled only in the position-0 bit of a slot. A change at any other time takes effect from the next slot.
- R10: sd_o and ws_o change only on the falling edge of clk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I2S bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_sel_i | input | 1 | Attenuation choice: 0 = shift 2, 1 = shift 3 |
| ws_i | input | 1 | Incoming word select |
| sd_i | input | 1 | Incoming serial data |
| ws_o | output | 1 | Outgoing word select, falling-edge launched |
| sd_o | output | 1 | Attenuated serial data, falling-edge launched |

## Verification
Every output bit is compared with an independent arithmetic model: the 32-bit slot word shifted right with sign extension.

Fixed words cover several distinct cases:
- full-scale positive and negative words;
- all-ones and all-zeros words;
- single-bit words;
- words with non-zero tail bits. Here a stale previous-slot bit at positions 1..N would show up.

A pseudo-random sweep then follows under both shift settings. It separates shift 2 from shift 3, and sign fill from zero fill. Some slots flip the shift selection in mid-slot. These show whether the choice is latched only at slot start. A prologue with ones on the data line before the first word-select change separates held-off output from pass-through.

// File: rtl/i2s_attn_pkg.sv
package i2s_attn_pkg;
  typedef enum logic {
    SEL_SHIFT_LO = 1'b0,
    SEL_SHIFT_HI = 1'b1
  } shift_sel_e;
endpackage

// File: rtl/attn_slot_tracker.sv
module attn_slot_tracker
  import i2s_attn_pkg::*;
#(
  parameter int SLOT_W   = 32,
  parameter int LO_SHIFT = 2,
  parameter int HI_SHIFT = 3,
  parameter int POS_W    = $clog2(SLOT_W),
  parameter int SH_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ws_i,
  input  logic             sel_i,
  output logic [POS_W-1:0] pos_o,
  output logic             lock_o,
  output logic [SH_W-1:0]  shamt_o
);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(SLOT_W - 1);

  logic             ws_q;
  logic             edge_q;
  logic             lock_q;
  logic [POS_W-1:0] pos_q;
  logic [SH_W-1:0]  shamt_q;
  shift_sel_e       sel_e;

  assign sel_e   = shift_sel_e'(sel_i);
  // edge_q marks the bit whose predecessor carried the ws change: slot position 0
  assign pos_o   = edge_q ? '0 : ((pos_q == POS_LAST) ? pos_q : pos_q + 1'b1);
  assign lock_o  = lock_q | edge_q;
  assign shamt_o = edge_q ? ((sel_e == SEL_SHIFT_HI) ? SH_W'(HI_SHIFT) : SH_W'(LO_SHIFT))
                          : shamt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_q    <= 1'b0;
      edge_q  <= 1'b0;
      lock_q  <= 1'b0;
      pos_q   <= POS_LAST;
      shamt_q <= SH_W'(LO_SHIFT);
    end else begin
      ws_q    <= ws_i;
      edge_q  <= ws_i ^ ws_q;
      lock_q  <= lock_o;
      pos_q   <= pos_o;
      shamt_q <= shamt_o;
    end
  end
endmodule

// File: rtl/attn_sign_path.sv
module attn_sign_path #(
  parameter int MAX_SH = 3,
  parameter int SH_W   = 2,
  parameter int POS_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sd_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             lock_i,
  input  logic [SH_W-1:0]  shamt_i,
  output logic             bit_o
);
  logic [MAX_SH:0] tap_w;
  logic            msb_q;

  assign tap_w[0] = sd_i;

  for (genvar k = 1; k <= MAX_SH; k++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap_w[k] <= 1'b0;
      else         tap_w[k] <= tap_w[k-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          msb_q <= 1'b0;
    else if (pos_i == '0) msb_q <= sd_i;
  end

  // positions 0..N repeat the sign; later ones take the delayed stream
  always_comb begin
    if (!lock_i)                        bit_o = 1'b0;
    else if (pos_i == '0)               bit_o = sd_i;
    else if (pos_i <= POS_W'(shamt_i))  bit_o = msb_q;
    else                                bit_o = tap_w[shamt_i];
  end
endmodule

// File: rtl/attn_launch.sv
module attn_launch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic ws_i,
  output logic sd_o,
  output logic ws_o
);
  logic bit_q;
  logic ws_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= 1'b0;
      ws_q  <= 1'b0;
    end else begin
      bit_q <= bit_i;
      ws_q  <= ws_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_o <= 1'b0;
      ws_o <= 1'b0;
    end else begin
      sd_o <= bit_q;
      ws_o <= ws_q;
    end
  end
endmodule

// File: rtl/i2s_shift_attn.sv
module i2s_shift_attn #(
  parameter int SLOT_W   = 32,
  parameter int LO_SHIFT = 2,
  parameter int HI_SHIFT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_sel_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic ws_o,
  output logic sd_o
);
  localparam int MAX_SH = (HI_SHIFT > LO_SHIFT) ? HI_SHIFT : LO_SHIFT;
  localparam int SH_W   = $clog2(MAX_SH + 1);
  localparam int POS_W  = $clog2(SLOT_W);

  logic [POS_W-1:0] pos_w;
  logic             lock_w;
  logic [SH_W-1:0]  shamt_w;
  logic             bit_w;

  attn_slot_tracker #(
    .SLOT_W(SLOT_W), .LO_SHIFT(LO_SHIFT), .HI_SHIFT(HI_SHIFT),
    .POS_W(POS_W), .SH_W(SH_W)
  ) u_trk (
    .clk_i(clk_i), .rst_ni(rst_ni), .ws_i(ws_i), .sel_i(shift_sel_i),
    .pos_o(pos_w), .lock_o(lock_w), .shamt_o(shamt_w)
  );

  attn_sign_path #(
    .MAX_SH(MAX_SH), .SH_W(SH_W), .POS_W(POS_W)
  ) u_path (
    .clk_i(clk_i), .rst_ni(rst_ni), .sd_i(sd_i), .pos_i(pos_w),
    .lock_i(lock_w), .shamt_i(shamt_w), .bit_o(bit_w)
  );

  attn_launch u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_w), .ws_i(ws_i),
    .sd_o(sd_o), .ws_o(ws_o)
  );
endmodule

// File: rtl/i2s_shift_attn_chk.sv
module i2s_shift_attn_chk #(
  parameter int POS_W = 5,
  parameter int SH_W  = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ws_i,
  input logic             sd_i,
  input logic             ws_o,
  input logic             sd_o,
  input logic             lock_w,
  input logic [POS_W-1:0] pos_w,
  input logic [SH_W-1:0]  shamt_w,
  input logic             bit_w
);
  // R2
  no_early_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_w |-> !bit_w);

  // R4
  slot_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ws_i != $past(ws_i)) |=> (pos_w == '0));

  // R4
  msb_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_w && pos_w == '0) |-> (bit_w == sd_i));

  // R9
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_w != '0) |-> $stable(shamt_w));

  // R3
  ws_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ws_o == $past(ws_i));

  // R10
  sd_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_o == $past(bit_w));
endmodule

bind i2s_shift_attn i2s_shift_attn_chk #(.POS_W(POS_W), .SH_W(SH_W)) u_chk (.*);

// File: tb/sim_i2s_shift_attn.sv
`timescale 1ns/1ps
module sim_i2s_shift_attn;
  localparam int NSLOT = 120;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic shift_sel_i = 1'b0;
  logic ws_i = 1'b0;
  logic sd_i = 1'b0;
  logic ws_o, sd_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic prev_sd = 1'b0;
  logic [31:0] lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  i2s_shift_attn u0 (
    .clk_i(clk), .rst_ni(rst_ni), .shift_sel_i(shift_sel_i),
    .ws_i(ws_i), .sd_i(sd_i), .ws_o(ws_o), .sd_o(sd_o)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic send_bit(input logic ws, input logic sd, input logic sel,
                          input logic exp, input string req);
    ws_i = ws; sd_i = sd; shift_sel_i = sel;
    @(posedge clk); #1;
    check(sd_o, prev_sd, "R10");
    @(negedge clk); #1;
    check(sd_o, exp, req);
    check(ws_o, ws, "R3");
    prev_sd = sd_o;
  endtask

  function automatic logic [31:0] word_of(input int i, input logic [31:0] rnd);
    case (i)
      0: return 32'h7FFF_0000;
      1: return 32'h8000_0000;
      2: return 32'hFFFF_0000;
      3: return 32'h0001_0000;
      4: return 32'hB3C5_0000;
      5: return 32'h0000_0000;
      6: return 32'h4000_0007;
      7: return 32'hC000_FFFF;
      8: return 32'h2AAA_000F;
      9: return 32'hD555_0000;
      default: return rnd;
    endcase
  endfunction

  initial begin
    // R1: reset holds outputs low
    sd_i = 1'b1;
    #12;
    check(sd_o, 1'b0, "R1");
    check(ws_o, 1'b0, "R1");
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    prev_sd = sd_o;
    // R2: no ws change yet, data must stay low
    for (int b = 0; b < 5; b++) send_bit(1'b0, 1'b1, 1'b0, 1'b0, "R2");
    send_bit(1'b1, 1'b1, 1'b0, 1'b0, "R2");
    for (int i = 0; i < NSLOT; i++) begin
      logic [31:0] w;
      logic signed [31:0] sh;
      logic ch, sel0, sel, mid_flip;
      int n;
      string req;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      w = word_of(i, lcg);
      ch = (i % 2 == 0);
      sel0 = ((i / 3) % 2 == 1);
      mid_flip = (i % 5 == 3);
      n = sel0 ? 3 : 2;
      sh = $signed(w) >>> n;
      for (int p = 0; p < 32; p++) begin
        sel = (mid_flip && p >= 10) ? ~sel0 : sel0;
        if (p == 0)      req = "R4";
        else if (p <= n) req = w[31] ? "R7 R8" : "R8";
        else if (mid_flip) req = "R9";
        else             req = sel0 ? "R6" : "R5";
        send_bit((p == 31) ? ~ch : ch, w[31-p], sel, sh[31-p], req);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule